// File: doc/BRIEF.md
# Sampling converter serial readout controller

This block is the digital back end of a 16-bit sampling converter. The host raises the conversion-start pin. That edge starts a conversion of fixed length and also takes the serial input's level to choose how the result leaves the device. If the serial input is high at that edge, the device works in select mode. The serial input and the conversion-start pin then act as two active-low selects, and the result is shifted out with the most significant bit first. If the serial input is low at that edge, the device works in chain mode. Each serial clock fall then shifts the serial input in behind the local result, so several devices can share one output line. The device nearest the host delivers its own word first, followed by the words of the devices further up the chain.

A behavioural converter stub stands in for the analog core. It captures the word presented on `conv_word` at the start edge and releases it a parameterised number of system clocks later, so each read returns the conversion it started. In select mode the device can also give a busy indicator. When the device is selected during the conversion, the output is driven high. When the device is still selected at completion, the output is pulled low until the first serial clock fall, and then the data bits follow. The three pins from the host pass through two-flop synchronisers, and their edges are detected in the block's clock domain.

Top module: `sar_sif`

## Requirements
- R1: After reset, `sdo_oe` is low and no conversion is in progress.
- R2: A rising edge on `cnvst` starts a conversion lasting `CONV_CYC` clocks. The result read out is the `conv_word` value present at that edge, and later changes to `conv_word` do not affect it.
- R3: The level of `sdi` at the `cnvst` rising edge selects the mode for that conversion: low selects chain mode and high selects select mode.
- R4: In select mode, after completion, `sdo_oe` is high only while `sdi` is low or `cnvst` is low. `sdo_oe` is low while both are high, and serial clock falls in that state do not advance the data.
- R5: In select mode without the busy indicator, bit 15 is on `sdo` as soon as the output is enabled. Each `sclk` falling edge moves to the next lower bit. After the 16th fall, `sdo_oe` goes low for the rest of the frame.
- R6: `sclk` edges that arrive while a conversion is in progress are ignored.
- R7: In select mode, while a conversion is in progress and `sdi` or `cnvst` is low, `sdo_oe` is high and `sdo` is 1.
- R8: If `sdi` or `cnvst` is low when a select-mode conversion completes, `sdo` reads 0 until the first `sclk` fall. That fall brings bit 15, and the frame ends after 17 falls.
- R9: In chain mode, once the conversion completes and while `cnvst` is low, `sdo_oe` is high. Each `sclk` fall shifts `sdi` into the bit below the word. In a chain of N devices, the host therefore receives 16·N bits, nearest device first and each word MSB first.
- R10: In chain mode, `sdo_oe` stays low while the conversion is in progress, and no busy indicator is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnvst | input | 1 | Conversion start; rising edge starts a conversion, low level selects |
| sclk | input | 1 | Serial clock from host; data advances on falling edges |
| sdi | input | 1 | Mode select at conversion start, select line or chain input afterwards |
| conv_word | input | DATA_W | Word returned by the converter stub for the conversion being started |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The hardest case to reach is the busy indicator that gets armed at completion. It needs select mode to be latched with `sdi` high, and then `sdi` must be lowered inside the conversion window, before the stub finishes. The bench drives `sdi` low a fixed number of clocks after the start edge, well inside `CONV_CYC`. It then checks the high busy level, the low level at completion and the extra leading fall. It also raises `sdi` partway through a frame to confirm that the output goes to high impedance and that serial clocks sent in that state are lost. For chain mode, three instances are wired output to input. The links are held low around each start edge so that every device latches chain mode, and the 48 bits are compared in order against the three loaded words.

// File: rtl/sif_pkg.sv
package sif_pkg;

  typedef enum logic {
    MODE_CHAIN  = 1'b0,
    MODE_SELECT = 1'b1
  } sif_mode_e;

  // Mode chosen by the serial input level at conversion start
  function automatic sif_mode_e pick_mode(input logic sdi_lvl);
    return sdi_lvl ? MODE_SELECT : MODE_CHAIN;
  endfunction

  // Device is selected: either active-low select in select mode, cnvst only in chain mode
  function automatic logic is_selected(input sif_mode_e m, input logic sdi_lvl,
                                       input logic cnv_lvl);
    return (m == MODE_SELECT) ? (!sdi_lvl || !cnv_lvl) : !cnv_lvl;
  endfunction

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[0], d[i]};
    end
    assign q[i] = ff[1];
  end
endmodule

// File: rtl/sif_edge.sv
module sif_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= 1'b0;
    else        prv <= lvl;
  end
  if (RISING) begin : g_rise
    assign pulse = lvl & ~prv;
  end else begin : g_fall
    assign pulse = ~lvl & prv;
  end
endmodule

// File: rtl/sif_conv.sv
module sif_conv #(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] word_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word_out
);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      word_out <= '0;
    end else if (start) begin
      cnt      <= CW'(CONV_CYC);
      word_out <= word_in;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/sif_shift.sv
module sif_shift
  import sif_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  logic              conv_busy,
  input  logic              cnv_lvl,
  input  logic              sdi_lvl,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] word,
  output sif_mode_e         mode,
  output logic              sel,
  output logic              rd_act,
  output logic              lead,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] shreg;
  logic              shift_en;
  logic              busy_drv;

  function automatic logic [DATA_W-1:0] next_word(input logic [DATA_W-1:0] w,
                                                  input logic fill);
    return {w[DATA_W-2:0], fill};
  endfunction

  assign sel      = is_selected(mode, sdi_lvl, cnv_lvl);
  assign shift_en = sclk_fall && rd_act && sel && !conv_busy;
  assign busy_drv = conv_busy && (mode == MODE_SELECT) && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_SELECT;
      rd_act  <= 1'b0;
      lead    <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (start) begin
      mode    <= pick_mode(sdi_lvl);
      rd_act  <= 1'b0;
      lead    <= 1'b0;
      bit_cnt <= '0;
    end else if (done) begin
      shreg   <= word;
      rd_act  <= 1'b1;
      bit_cnt <= '0;
      lead    <= (mode == MODE_SELECT) && sel;
    end else if (shift_en) begin
      if (lead) begin
        lead <= 1'b0;
      end else begin
        shreg <= next_word(shreg, (mode == MODE_CHAIN) ? sdi_lvl : 1'b0);
        if (mode == MODE_SELECT) begin
          if (bit_cnt == CNT_W'(DATA_W - 1)) begin
            rd_act  <= 1'b0;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign sdo_oe = busy_drv || (rd_act && sel);
  assign sdo    = busy_drv ? 1'b1 : (lead ? 1'b0 : shreg[DATA_W-1]);
endmodule

// File: rtl/sar_sif.sv
module sar_sif
  import sif_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnvst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] conv_word,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [2:0]        lvl;
  logic              cnv_lvl, sclk_lvl, sdi_lvl;
  logic              conv_start, sclk_fall;
  logic              conv_busy, conv_done;
  logic [DATA_W-1:0] conv_q;
  sif_mode_e         mode;
  logic              sel, rd_act, lead;
  logic [CNT_W-1:0]  bit_cnt;

  sif_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sdi, sclk, cnvst}), .q(lvl)
  );
  assign cnv_lvl  = lvl[0];
  assign sclk_lvl = lvl[1];
  assign sdi_lvl  = lvl[2];

  sif_edge #(.RISING(1'b1)) u_cnv_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cnv_lvl), .pulse(conv_start)
  );
  sif_edge #(.RISING(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_lvl), .pulse(sclk_fall)
  );

  sif_conv #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .word_in(conv_word),
    .busy(conv_busy), .done(conv_done), .word_out(conv_q)
  );

  sif_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .done(conv_done),
    .conv_busy(conv_busy), .cnv_lvl(cnv_lvl), .sdi_lvl(sdi_lvl),
    .sclk_fall(sclk_fall), .word(conv_q), .mode(mode), .sel(sel),
    .rd_act(rd_act), .lead(lead), .bit_cnt(bit_cnt), .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/sar_sif_chk.sv
module sar_sif_chk
  import sif_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 40,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             conv_done,
  input logic             conv_busy,
  input logic             sdi_lvl,
  input logic             cnv_lvl,
  input sif_mode_e        mode,
  input logic             lead,
  input logic             rd_act,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdo,
  input logic             sdo_oe
);
  int unsigned age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 0;
    else if (conv_start) age <= 0;
    else if (conv_busy)  age <= age + 1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> !sdo_oe && !conv_busy);

  // R2
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> age == CONV_CYC - 1);

  // R3
  mode_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> mode == ($past(sdi_lvl) ? MODE_SELECT : MODE_CHAIN));

  // R4
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SELECT) && sdi_lvl && cnv_lvl |-> !sdo_oe);

  // R5
  frame_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(DATA_W));

  // R6
  conv_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !rd_act && !lead);

  // R7
  busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && sdo_oe |-> sdo);

  // R8
  lead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead && sdo_oe |-> !sdo && mode == MODE_SELECT);

  // R10
  chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && mode == MODE_CHAIN |-> !sdo_oe);
endmodule

bind sar_sif sar_sif_chk #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_sar_sif_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .conv_busy(conv_busy), .sdi_lvl(sdi_lvl), .cnv_lvl(cnv_lvl), .mode(mode),
  .lead(lead), .rd_act(rd_act), .bit_cnt(bit_cnt), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/sar_sif_bench.sv
`timescale 1ns/1ps
module sar_sif_bench;
  localparam int W    = 16;
  localparam int CONV = 40;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnvst = 1'b0;
  logic sclk = 1'b0;
  logic tb_sdi = 1'b1;
  logic use_tb = 1'b1;
  logic link_en = 1'b0;
  logic [W-1:0] w0 = '0, w1 = '0, w2 = '0;
  logic sdo0, oe0, sdo1, oe1, sdo2, oe2;
  logic sdi0, sdi1;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sdi1 = link_en & oe2 & sdo2;
  assign sdi0 = use_tb ? tb_sdi : (link_en & oe1 & sdo1);

  sar_sif #(.DATA_W(W), .CONV_CYC(CONV)) u_sar_sif (
    .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .sclk(sclk), .sdi(sdi0),
    .conv_word(w0), .sdo(sdo0), .sdo_oe(oe0));
  sar_sif #(.DATA_W(W), .CONV_CYC(CONV)) u_up1 (
    .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .sclk(sclk), .sdi(sdi1),
    .conv_word(w1), .sdo(sdo1), .sdo_oe(oe1));
  sar_sif #(.DATA_W(W), .CONV_CYC(CONV)) u_up2 (
    .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .sclk(sclk), .sdi(1'b0),
    .conv_word(w2), .sdo(sdo2), .sdo_oe(oe2));

  function automatic logic [3*W-1:0] chain_stream(input logic [W-1:0] a, b, c);
    return {a, b, c};
  endfunction

  function automatic int frame_falls(input bit busy);
    return busy ? W + 1 : W;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; tick(HALF);
    sclk = 1'b0; tick(HALF);
  endtask

  // Select-mode read; busy: select via sdi during conversion; ign: sclk during conversion
  task automatic cs_read(input logic [W-1:0] word, input bit busy, input bit ign,
                         input bit pause);
    int k;
    cnvst = 1'b0; tb_sdi = 1'b1; use_tb = 1'b1; link_en = 1'b0;
    tick(10);
    w0 = word;
    cnvst = 1'b1; tick(6);
    w0 = ~word;                       // R2: later changes must not matter
    if (busy) begin
      tb_sdi = 1'b0; tick(6);
      chk("R7 busy oe", oe0, 1'b1);
      chk("R7 busy level", sdo0, 1'b1);
    end else if (ign) begin
      sclk_pulse();                   // R6: falls inside conversion window
    end
    tick(CONV + 10);
    if (busy) begin
      chk("R8 done oe", oe0, 1'b1);
      chk("R8 done low", sdo0, 1'b0);
      sclk_pulse();
    end else begin
      chk("R4 deselected hiz", oe0, 1'b0);
      cnvst = 1'b0; tick(10);
      chk("R5 enable oe", oe0, 1'b1);
    end
    k = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pause && busy && k == 6) begin
        tb_sdi = 1'b1; tick(10);      // both high -> deselected
        chk("R4 mid-frame hiz", oe0, 1'b0);
        sclk_pulse();                 // must not advance
        tb_sdi = 1'b0; tick(10);
      end
      chk(busy ? "R8 data bit" : (ign ? "R6 data bit" : "R5 data bit"), sdo0, word[i]);
      sclk_pulse();
      k++;
    end
    chk("R5 frame end hiz", oe0, 1'b0);
    if (k + (busy ? 1 : 0) != frame_falls(busy)) errors++;
    tb_sdi = 1'b1;
  endtask

  task automatic dc_read(input logic [W-1:0] a, b, c);
    logic [3*W-1:0] exp;
    cnvst = 1'b0; use_tb = 1'b1; tb_sdi = 1'b0; link_en = 1'b0;
    tick(10);
    w0 = a; w1 = b; w2 = c;
    cnvst = 1'b1; tick(10);
    chk("R10 chain busy quiet", oe0, 1'b0);
    w0 = ~a; w1 = ~b; w2 = ~c;
    tick(CONV + 10);
    chk("R10 cnvst high quiet", oe0, 1'b0);
    link_en = 1'b1; use_tb = 1'b0;
    cnvst = 1'b0; tick(10);
    chk("R9 chain oe", oe0, 1'b1);
    exp = chain_stream(a, b, c);
    for (int i = 3 * W - 1; i >= 0; i--) begin
      chk("R9 chain bit", sdo0, exp[i]);
      sclk_pulse();
    end
    cnvst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    chk("R1 reset oe", oe0, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 idle oe", oe0, 1'b0);

    // directed corners
    cs_read(16'h8001, 1'b0, 1'b0, 1'b0);   // R3 select mode latched from sdi high
    cs_read(16'hFFFF, 1'b0, 1'b1, 1'b0);   // R6
    cs_read(16'h0000, 1'b1, 1'b0, 1'b0);   // R8
    cs_read(16'hA5C3, 1'b1, 1'b0, 1'b1);   // R4 mid-frame deselect
    dc_read(16'h1234, 16'hFEDC, 16'h8001); // R3 chain mode latched from sdi low
    dc_read(16'hFFFF, 16'h0000, 16'hFFFF);

    // constrained random
    for (int n = 0; n < 6; n++) begin
      logic [W-1:0] r;
      bit b, g;
      r = W'($urandom);
      b = 1'($urandom_range(1, 0));
      g = b ? 1'b0 : 1'($urandom_range(1, 0));
      cs_read(r, b, g, b & 1'($urandom_range(1, 0)));
    end
    for (int n = 0; n < 4; n++) begin
      dc_read(W'($urandom), W'($urandom), W'($urandom));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule